// File: doc/BRIEF.md
# Serial Port Baud Clock Divider

This block divides a reference clock into the 16x-oversampling clock that a serial transmitter and receiver use. The reference clock is an enable pulse, `ref_en`, in the block's own system clock domain, and every count is measured in reference pulses. A 16-bit divisor sits in two byte-wide registers that the host loads with single byte writes. The block drives two outputs. `div_out` is the divided waveform. `baud_tick` is a one-cycle strobe at the start of each divided period, and the serial logic samples on it.

For divisors of 3 and above the block divides in the plain way. The values 0, 1 and 2 each produce their own waveform. A write to either byte register restarts the period at once, so a new setting takes effect without waiting out an old count. After reset both bytes are zero, and the block runs in its divide-by-3 mode until the host programs it.

Top module: `baud_div_top`

## Requirements
- R1: A synchronous reset clears both divisor bytes, `div_out` and `baud_tick` to 0. Later reference pulses then follow the divisor-0 behaviour of R5.
- R2: A write with `wr_sel` = 0 loads `wr_data` into divisor bits 7:0. A write with `wr_sel` = 1 loads bits 15:8. The other byte keeps its value.
- R3: The clock edge that takes a write restarts the period. After that edge `div_out` is 0 and `baud_tick` is 0. Reference pulses are then counted from the start of a new period of the newly written divisor.
- R4: With a divisor D of 3 or more, each period lasts D reference pulses. `div_out` is 0 for the first 2 pulse intervals and 1 for the remaining D-2.
- R5: With a divisor of 0, each period lasts 3 reference pulses. `div_out` is 0 for the first pulse interval and 1 for the other two.
- R6: With a divisor of 2, each period lasts 2 reference pulses. `div_out` is 0 for one pulse interval and 1 for the next (50% duty).
- R7: With a divisor of 1, every reference pulse ends a period. `div_out` inverts on every pulse, starting from 0 after a write.
- R8: `baud_tick` is 1 for exactly the one clock that follows the reference pulse that ends a period, and 0 in every other cycle. `div_out` changes only on the clock edge that takes a reference pulse, a write or a reset.
- R9: When a write and a reference pulse arrive in the same cycle, the write takes effect as in R3 and that pulse is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | Reference clock enable, one pulse per reference period |
| wr_en | input | 1 | Byte write strobe for the divisor registers |
| wr_sel | input | 1 | Byte select: 0 low byte, 1 high byte |
| wr_data | input | 8 | Byte to write |
| div_out | output | 1 | Divided waveform |
| baud_tick | output | 1 | One-cycle strobe at each period start |

## Verification
Both outputs are registered. A result is due one clock after the edge that takes a reference pulse or a write. The bench drives every stimulus for one cycle starting at a falling edge, and it reads the outputs at the next falling edge, which sits half a cycle after that register update. After each reference pulse the bench reads one more falling edge, one cycle later. There it confirms that the tick has dropped and that the waveform has held its level. The expected phase, level and tick come from counting pulses since the last write or reset, using the period and low-time rules of each divisor class.

// File: rtl/baud_div_pkg.sv
`timescale 1ns/1ps
package baud_div_pkg;

    localparam int DIV_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int N_BYTES = DIV_W / BYTE_W;
    localparam int SEL_W   = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;
    localparam int NORM_LOW = 2;   // low pulse intervals for divisors >= 3

    typedef logic [DIV_W-1:0] div_t;

    typedef enum logic [1:0] {
        MODE_DIV3 = 2'd0,   // divisor 0: fixed divide by 3
        MODE_INV  = 2'd1,   // divisor 1: toggle every pulse
        MODE_HALF = 2'd2,   // divisor 2: 50% duty divide by 2
        MODE_NORM = 2'd3    // divisor >= 3: low for NORM_LOW pulses
    } wave_mode_e;

    typedef struct packed {
        wave_mode_e mode;
        div_t       period;
    } wave_cfg_t;

    function automatic wave_cfg_t cfg_of(div_t d);
        wave_cfg_t c;
        c.period = d;
        if (d == div_t'(0)) begin
            c.mode   = MODE_DIV3;
            c.period = div_t'(3);
        end else if (d == div_t'(1)) begin
            c.mode = MODE_INV;
        end else if (d == div_t'(2)) begin
            c.mode = MODE_HALF;
        end else begin
            c.mode = MODE_NORM;
        end
        return c;
    endfunction

    function automatic logic low_at(wave_mode_e m, div_t ph);
        logic lo;
        case (m)
            MODE_NORM: lo = (ph < div_t'(NORM_LOW));
            default:   lo = (ph == div_t'(0));
        endcase
        return lo;
    endfunction

endpackage

// File: rtl/baud_div_latch.sv
`timescale 1ns/1ps
module baud_div_latch
    import baud_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output div_t              divisor,
    output logic              reload
);

    logic [BYTE_W-1:0] bytes_q [N_BYTES];

    for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                bytes_q[i] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(i)))
                bytes_q[i] <= wr_data;
        end

        assign divisor[i*BYTE_W +: BYTE_W] = bytes_q[i];

        // R2: a write lands in the selected byte only
        a_r2_byte_lands: assert property (@(posedge clk) disable iff (rst)
            ($past(wr_en && (wr_sel == SEL_W'(i))) && !$past(rst))
                |-> (bytes_q[i] == $past(wr_data)));
        a_r2_byte_kept: assert property (@(posedge clk) disable iff (rst)
            (!$past(wr_en && (wr_sel == SEL_W'(i))) && !$past(rst))
                |-> $stable(bytes_q[i]));
    end

    assign reload = wr_en;

endmodule

// File: rtl/baud_div_counter.sv
`timescale 1ns/1ps
module baud_div_counter
    import baud_div_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic reload,
    input  logic step,
    input  div_t period,
    output div_t phase,
    output div_t phase_nxt,
    output logic wrap
);

    div_t phase_q;

    always_comb begin
        wrap = step && (phase_q == period - div_t'(1));
        if (reload || wrap)
            phase_nxt = '0;
        else if (step)
            phase_nxt = phase_q + div_t'(1);
        else
            phase_nxt = phase_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else
            phase_q <= phase_nxt;
    end

    assign phase = phase_q;

    // R4: the phase never reaches the programmed period
    a_r4_phase_in_period: assert property (@(posedge clk) disable iff (rst)
        phase_q < period);

    // R9: a pulse that arrives with a write is not counted
    a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
        ($past(reload) && !$past(rst)) |-> (phase_q == div_t'(0)));

endmodule

// File: rtl/baud_div_shaper.sv
`timescale 1ns/1ps
module baud_div_shaper
    import baud_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reload,
    input  logic       step,
    input  logic       wrap,
    input  wave_mode_e mode,
    input  div_t       phase_nxt,
    output logic       div_out,
    output logic       tick
);

    logic level_q;
    logic tick_q;

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            level_q <= 1'b0;
            tick_q  <= 1'b0;
        end else begin
            tick_q <= wrap;
            if (step) begin
                if (mode == MODE_INV)
                    level_q <= ~level_q;
                else
                    level_q <= ~low_at(mode, phase_nxt);
            end
        end
    end

    assign div_out = level_q;
    assign tick    = tick_q;

    // R8: a tick only follows a counted pulse
    a_r8_tick_after_pulse: assert property (@(posedge clk) disable iff (rst)
        tick_q |-> $past(step));

    // R8: the waveform holds when nothing happened
    a_r8_level_holds: assert property (@(posedge clk) disable iff (rst)
        (!$past(step) && !$past(reload) && !$past(rst)) |-> $stable(level_q));

    // R7: divisor 1 inverts on every counted pulse
    a_r7_inverts: assert property (@(posedge clk) disable iff (rst)
        ($past(step) && !$past(rst) && (mode == MODE_INV))
            |-> (level_q != $past(level_q)));

endmodule

// File: rtl/baud_div_top.sv
`timescale 1ns/1ps
module baud_div_top
    import baud_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_en,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              div_out,
    output logic              baud_tick
);

    div_t      divisor;
    logic      reload;
    logic      step;
    wave_cfg_t cfg;
    div_t      phase;
    div_t      phase_nxt;
    logic      wrap;

    baud_div_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .divisor (divisor),
        .reload  (reload)
    );

    assign cfg  = cfg_of(divisor);
    assign step = ref_en && !reload;

    baud_div_counter u_counter (
        .clk       (clk),
        .rst       (rst),
        .reload    (reload),
        .step      (step),
        .period    (cfg.period),
        .phase     (phase),
        .phase_nxt (phase_nxt),
        .wrap      (wrap)
    );

    baud_div_shaper u_shaper (
        .clk       (clk),
        .rst       (rst),
        .reload    (reload),
        .step      (step),
        .wrap      (wrap),
        .mode      (cfg.mode),
        .phase_nxt (phase_nxt),
        .div_out   (div_out),
        .tick      (baud_tick)
    );

    // R3: a write restarts the period with the output low and no tick
    a_r3_restart: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst))
            |-> ((phase == div_t'(0)) && !baud_tick && !div_out));

    // R1: reset leaves both outputs low
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!div_out && !baud_tick));

endmodule

// File: tb/sim_baud_div_top.sv
`timescale 1ns/1ps
module sim_baud_div_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [0:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       div_out;
    logic       baud_tick;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    baud_div_top u0 (
        .clk       (clk),
        .rst       (rst),
        .ref_en    (ref_en),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .div_out   (div_out),
        .baud_tick (baud_tick)
    );

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_byte(int sel, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel[0:0]; wr_data = data[7:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_div(int d);
        write_byte(1, (d >> 8) & 255);
        write_byte(0, d & 255);
        chk("R3 restart level", div_out, 0);
        chk("R3 restart tick", baud_tick, 0);
    endtask

    task automatic one_pulse();
        @(negedge clk) ref_en = 1'b1;
        @(negedge clk) ref_en = 1'b0;
    endtask

    // Pulses counted from a fresh period; expected values from R4-R8.
    task automatic expect_pulses(int d, int n, string req);
        int p = (d == 0) ? 3 : d;
        for (int k = 1; k <= n; k++) begin
            int ph = k % p;
            int e_div;
            int e_tick;
            if (d == 1) begin
                e_div = k % 2;
                e_tick = 1;
            end else begin
                e_tick = (ph == 0) ? 1 : 0;
                if (d >= 3) e_div = (ph < 2) ? 0 : 1;
                else        e_div = (ph == 0) ? 0 : 1;
            end
            one_pulse();
            chk({req, " level"}, div_out, e_div);
            chk({req, " tick"}, baud_tick, e_tick);
            @(negedge clk);
            chk("R8 tick drops", baud_tick, 0);
            chk("R8 level holds", div_out, e_div);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 level", div_out, 0);
        chk("R1 tick", baud_tick, 0);
        expect_pulses(0, 7, "R1 R5 div3");
    endtask

    task automatic t_norm();
        set_div(3);
        expect_pulses(3, 9, "R4 d3");
        set_div(5);
        expect_pulses(5, 10, "R4 d5");
    endtask

    task automatic t_half();
        set_div(2);
        expect_pulses(2, 6, "R6 d2");
    endtask

    task automatic t_inv();
        set_div(1);
        expect_pulses(1, 6, "R7 d1");
    endtask

    task automatic t_bytes();
        set_div(16'h0104);
        expect_pulses(16'h0104, 2 * 16'h0104, "R2 d260");
    endtask

    task automatic t_reload();
        set_div(5);
        expect_pulses(5, 3, "R4 pre");
        write_byte(0, 7);
        chk("R3 mid level", div_out, 0);
        chk("R3 mid tick", baud_tick, 0);
        expect_pulses(7, 14, "R3 d7");
    endtask

    task automatic t_collide();
        set_div(4);
        expect_pulses(4, 2, "R4 pre");
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'd6; ref_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ref_en = 1'b0;
        chk("R9 level", div_out, 0);
        chk("R9 tick", baud_tick, 0);
        expect_pulses(6, 12, "R9 d6");
    endtask

    task automatic t_reset_mid();
        set_div(5);
        expect_pulses(5, 3, "R4 pre");
        do_reset();
        chk("R1 mid level", div_out, 0);
        chk("R1 mid tick", baud_tick, 0);
        expect_pulses(0, 6, "R1 mid div3");
    endtask

    initial begin
        t_reset();
        t_norm();
        t_half();
        t_inv();
        t_bytes();
        t_reload();
        t_collide();
        t_reset_mid();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule